// File: doc/BRIEF.md
# PAM Burst Waveform Sequencer

This block produces the 4-bit level-select stream for a push-pull, pulse-amplitude-modulated transmit stage, one code for each sample clock. A single 4-bit code carries each sample, so the two output legs can never be selected together: zero turns both legs off, codes 1 to 7 pick a level on leg A, and codes 8 to 15 pick a level on leg B. A built-in table holds half of a windowed sine burst as signed level values. A burst plays that half forward and then back again in mirror order. With the default table length this gives 45 samples. The stream then returns to the off code.

A burst is launched by a rising edge on an asynchronous trigger input. A phase index adds a launch delay. The index has 48 steps, one per 7.5 degrees, and each step is a fixed number of sample clocks. A polarity input swaps the leg-A and leg-B selections for the whole burst. The run control stops the sequencer. While it is low, the sequencer stays idle.

Top module: `pam_burst_seq`

## Requirements
- R1: After reset, mCode is 0000 and busy is 0.
- R2: A signed sample s maps to a code as follows. s = 0 gives 0000 (both legs off). s from 1 to 7 gives code s (leg A). s from -1 to -8 gives code 7 + |s|, which lies in 8 to 15 (leg B).
- R3: Table entry i (0 <= i < HALF_LEN) is trunc(w[i mod 16] * min(7, floor(i/2)+1) / 7), where trunc rounds toward zero. Over one 16-sample carrier cycle, w is 0,3,5,6,7,6,5,3,0,-3,-5,-6,-7,-6,-5,-3.
- R4: A burst presents 2*HALF_LEN-1 samples on consecutive clocks: entries 0 up to HALF_LEN-1, then entries HALF_LEN-2 down to 0. With the default HALF_LEN of 23 this is 45 samples.
- R5: trigIn passes through two synchronizing flops. A rising edge launches a burst only when the sequencer is idle and runEn is high. Take edge k as the first clock edge that samples trigIn high, and D as the launch delay. Sample j then appears on mCode after edge k+4+D+j.
- R6: The launch delay is D = min(phaseIdx, 47) * TICKS_PER_STEP clocks. phaseIdx is captured at launch.
- R7: When polarityInv is high at launch, every sample is negated before it is mapped, and -8 becomes +7. Changes to polarityInv during a burst have no effect.
- R8: A trigger rising edge that arrives during a burst is ignored. The burst runs on unchanged, and no second burst follows.
- R9: With runEn low, mCode is 0000 and busy is 0 from the next clock edge. Triggers are ignored while runEn is low.
- R10: busy rises on edge k+2 and falls on edge k+3+D+2*HALF_LEN-1, which is the edge that presents the last sample. mCode is 0000 one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigIn | input | 1 | Asynchronous burst trigger, rising edge |
| runEn | input | 1 | High allows bursts; low stops and idles |
| polarityInv | input | 1 | High swaps leg A and leg B for the next burst |
| phaseIdx | input | 6 | Launch phase step, saturating at 47 |
| mCode | output | 4 | Level-select code to the output stage |
| busy | output | 1 | High while a burst is pending or playing |

## Verification
The assertions check every cycle that the table index stays in range, that the mirror half counts down one step at a time, that the output returns to the off code whenever play is not enabled, that a launch raises busy, that a trigger during playback never restarts the delay, and that an out-of-range phase loads the saturated delay. Only the bench scenarios can show the exact sample values and their mirrored order, the launch latency measured from the trigger pin, and the effect of each phase setting. The same applies to the polarity latched at launch, which holds through a mid-burst toggle, and to the run-stop cut-off, since each of these needs an expected value derived from the table formula.

// File: rtl/pam_seq_pkg.sv
package pam_seq_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             play;
    logic             invert;
    logic [IDX_W-1:0] idx;
  } seqStrobe_t;

  // signed level for table entry i: carrier shape times a rising window
  function automatic logic signed [3:0] levelAt(input logic [IDX_W-1:0] i);
    int wave;
    int ramp;
    int prod;
    case (i[3:0])
      4'd0:  wave = 0;
      4'd1:  wave = 3;
      4'd2:  wave = 5;
      4'd3:  wave = 6;
      4'd4:  wave = 7;
      4'd5:  wave = 6;
      4'd6:  wave = 5;
      4'd7:  wave = 3;
      4'd8:  wave = 0;
      4'd9:  wave = -3;
      4'd10: wave = -5;
      4'd11: wave = -6;
      4'd12: wave = -7;
      4'd13: wave = -6;
      4'd14: wave = -5;
      default: wave = -3;
    endcase
    ramp = int'(i >> 1) + 1;
    if (ramp > 7) ramp = 7;
    prod = (wave * ramp) / 7;
    return 4'(prod);
  endfunction
endpackage

// File: rtl/pam_trig_sync.sv
module pam_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic trigAsync,
  output logic trigRise
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   lastLvl;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= trigAsync;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) lastLvl <= 1'b0;
    else       lastLvl <= chain[SYNC_STAGES-1];

  assign trigRise = chain[SYNC_STAGES-1] & ~lastLvl;
endmodule

// File: rtl/pam_seq_ctrl.sv
module pam_seq_ctrl
  import pam_seq_pkg::*;
#(
  parameter int HALF_LEN       = 23,
  parameter int PHASE_W        = 6,
  parameter int PHASE_STEPS    = 48,
  parameter int TICKS_PER_STEP = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigRise,
  input  logic               runEn,
  input  logic               polarityInv,
  input  logic [PHASE_W-1:0] phaseIdx,
  output seqStrobe_t         strobe,
  output logic               busy
);
  localparam int MAX_PHASE = PHASE_STEPS - 1;
  localparam int MAX_DELAY = MAX_PHASE * TICKS_PER_STEP;
  localparam int CNT_W     = $clog2(MAX_DELAY + 2);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HALF_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_DELAY, S_FWD, S_REV} seqState_t;

  seqState_t        state;
  logic [CNT_W-1:0] delayCnt;
  logic [IDX_W-1:0] idx;
  logic             invLatch;
  logic             launch;
  logic [PHASE_W-1:0] phaseSat;

  assign phaseSat = (int'(phaseIdx) > MAX_PHASE) ? PHASE_W'(MAX_PHASE) : phaseIdx;
  assign launch   = (state == S_IDLE) && runEn && trigRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      delayCnt <= '0;
      idx      <= '0;
      invLatch <= 1'b0;
    end else if (!runEn) begin
      state    <= S_IDLE;
      delayCnt <= '0;
      idx      <= '0;
    end else begin
      case (state)
        S_IDLE: if (launch) begin
          state    <= S_DELAY;
          delayCnt <= CNT_W'(int'(phaseSat) * TICKS_PER_STEP);
          invLatch <= polarityInv;
        end
        S_DELAY: if (delayCnt == '0) begin
          state <= S_FWD;
          idx   <= '0;
        end else begin
          delayCnt <= delayCnt - 1'b1;
        end
        S_FWD: if (idx == LAST_IDX) begin
          if (HALF_LEN > 1) begin
            state <= S_REV;
            idx   <= idx - 1'b1;
          end else begin
            state <= S_IDLE;
          end
        end else begin
          idx <= idx + 1'b1;
        end
        default: if (idx == '0) begin
          state <= S_IDLE;
        end else begin
          idx <= idx - 1'b1;
        end
      endcase
    end
  end

  assign strobe.play   = runEn && ((state == S_FWD) || (state == S_REV));
  assign strobe.invert = invLatch;
  assign strobe.idx    = idx;
  assign busy          = (state != S_IDLE);

  // R5: an accepted trigger makes the sequencer busy on the next edge
  assert_launch_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> busy);
  // R8: a trigger edge during playback never restarts the launch delay
  assert_retrig_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_FWD) || (state == S_REV)) && trigRise |=> state != S_DELAY);
  // R6: phase above the last step loads the saturated delay
  assert_phase_sat_R6: assert property (@(posedge clk) disable iff (!rstN)
    launch && (int'(phaseIdx) > MAX_PHASE) |=> delayCnt == CNT_W'(MAX_DELAY));
  // R4: table index stays within the stored half
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.play |-> idx <= LAST_IDX);
  // R4: mirror half steps down by one
  assert_rev_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_REV) && runEn && (idx != '0) |=> idx == $past(idx) - 1'b1);
endmodule

// File: rtl/pam_seq_dp.sv
module pam_seq_dp
  import pam_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic [3:0] mCode
);
  logic signed [3:0] rawLvl;
  logic signed [3:0] polLvl;
  logic        [3:0] nextCode;

  always_comb begin
    rawLvl = levelAt(strobe.idx);
    if (strobe.invert) polLvl = (rawLvl == -4'sd8) ? 4'sd7 : -rawLvl;
    else               polLvl = rawLvl;
    if (polLvl == 4'sd0)  nextCode = 4'd0;
    else if (!polLvl[3])  nextCode = unsigned'(polLvl);
    else                  nextCode = 4'd7 + unsigned'(4'(-polLvl));
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            mCode <= 4'd0;
    else if (strobe.play) mCode <= nextCode;
    else                  mCode <= 4'd0;

  // R9: output falls back to the off code whenever play is not enabled
  assert_off_when_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.play |=> mCode == 4'd0);
  // R2: a positive level never selects leg B
  assert_leg_a_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.play && (polLvl > 4'sd0) |=> (mCode != 4'd0) && !mCode[3]);
endmodule

// File: rtl/pam_burst_seq.sv
module pam_burst_seq
  import pam_seq_pkg::*;
#(
  parameter int HALF_LEN       = 23,
  parameter int PHASE_W        = 6,
  parameter int PHASE_STEPS    = 48,
  parameter int TICKS_PER_STEP = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigIn,
  input  logic               runEn,
  input  logic               polarityInv,
  input  logic [PHASE_W-1:0] phaseIdx,
  output logic [3:0]         mCode,
  output logic               busy
);
  seqStrobe_t strobe;
  logic       trigRise;

  pam_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .trigAsync(trigIn), .trigRise(trigRise));

  pam_seq_ctrl #(
    .HALF_LEN(HALF_LEN), .PHASE_W(PHASE_W),
    .PHASE_STEPS(PHASE_STEPS), .TICKS_PER_STEP(TICKS_PER_STEP)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .trigRise(trigRise), .runEn(runEn),
    .polarityInv(polarityInv), .phaseIdx(phaseIdx),
    .strobe(strobe), .busy(busy));

  pam_seq_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mCode(mCode));
endmodule

// File: tb/pam_burst_seq_tb_top.sv
module pam_burst_seq_tb_top;
  localparam int N     = 23;
  localparam int TICKS = 2;
  localparam int L     = 2 * N - 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       trigIn = 1'b0;
  logic       runEn = 1'b1;
  logic       polarityInv = 1'b0;
  logic [5:0] phaseIdx = '0;
  logic [3:0] mCode;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pam_burst_seq #(.HALF_LEN(N), .TICKS_PER_STEP(TICKS)) dut_i (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .runEn(runEn),
    .polarityInv(polarityInv), .phaseIdx(phaseIdx), .mCode(mCode), .busy(busy));

  function automatic int waveAt(int p);
    int w[16] = '{0, 3, 5, 6, 7, 6, 5, 3, 0, -3, -5, -6, -7, -6, -5, -3};
    return w[p];
  endfunction

  // R3 table formula
  function automatic int levelRef(int i);
    int ramp = i / 2 + 1;
    if (ramp > 7) ramp = 7;
    return (waveAt(i % 16) * ramp) / 7;
  endfunction

  // R2 mapping, R4 order, R7 polarity
  function automatic int codeRef(int j, bit inv);
    int i = (j < N) ? j : (2 * N - 2 - j);
    int s = levelRef(i);
    if (inv) s = (s == -8) ? 7 : -s;
    if (s == 0) return 0;
    if (s > 0) return s;
    return 7 - s;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idleGap(int n);
    trigIn = 1'b0;
    for (int c = 0; c < n; c++) @(negedge clk);
  endtask

  // drives one burst and checks mCode and busy after every edge
  task automatic playAndCheck(int ph, bit inv, bit flipPol, bit reTrig, int stopAt, string req);
    int d = ((ph > 47) ? 47 : ph) * TICKS;
    phaseIdx = 6'(ph);
    polarityInv = inv;
    @(negedge clk);
    trigIn = 1'b1;
    for (int n = 0; n <= d + L + 6; n++) begin
      int expM;
      int expB;
      int j;
      @(posedge clk);
      @(negedge clk);
      j = n - 4 - d;
      if (stopAt >= 0 && n > stopAt) begin
        expM = 0;
        expB = 0;
      end else begin
        expM = (j >= 0 && j < L) ? codeRef(j, inv) : 0;
        expB = (n >= 2 && n <= d + 2 + L) ? 1 : 0;
      end
      check(int'(mCode) == expM, req, int'(mCode), expM);
      check(int'(busy) == expB, {req, " R10 busy"}, int'(busy), expB);
      if (flipPol && n == 6) polarityInv = ~inv;
      if (reTrig && n == 8) trigIn = 1'b0;
      if (reTrig && n == 12) trigIn = 1'b1;
      if (stopAt >= 0 && n == stopAt) runEn = 1'b0;
    end
    idleGap(4);
    runEn = 1'b1;
    idleGap(4);
  endtask

  task automatic testReset();
    check(mCode == 4'd0, "R1 reset code", int'(mCode), 0);
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
  endtask

  task automatic testBasic();   // R2 R3 R4 R5 R10
    playAndCheck(0, 1'b0, 1'b0, 1'b0, -1, "R4 basic burst");
  endtask

  task automatic testPhasePolarity();   // R6 R7
    playAndCheck(5, 1'b1, 1'b1, 1'b0, -1, "R7 inverted with toggle, R6 phase 5");
  endtask

  task automatic testPhaseSat();   // R6
    playAndCheck(60, 1'b0, 1'b0, 1'b0, -1, "R6 saturated phase");
  endtask

  task automatic testRetrigger();   // R8
    playAndCheck(1, 1'b0, 1'b0, 1'b1, -1, "R8 retrigger ignored");
  endtask

  task automatic testRunStop();   // R9
    playAndCheck(0, 1'b0, 1'b0, 1'b0, 4 + 5, "R9 run stop");
  endtask

  task automatic testTrigWhileStopped();   // R9
    runEn = 1'b0;
    @(negedge clk);
    trigIn = 1'b1;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      check(mCode == 4'd0, "R9 stopped code", int'(mCode), 0);
      check(busy == 1'b0, "R9 stopped busy", int'(busy), 0);
    end
    trigIn = 1'b0;
    idleGap(4);
    runEn = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      check(busy == 1'b0, "R9 no late launch", int'(busy), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    idleGap(3);
    testBasic();
    testPhasePolarity();
    testPhaseSat();
    testRetrigger();
    testRunStop();
    testTrigWhileStopped();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule